// File: doc/BRIEF.md
# Receive Flow Threshold Controller

This block drives the active-low request-to-send line of a serial receiver from the fill level of its receive queue. The queue holds 64 characters. Software loads one 8-bit threshold word. Its low nibble holds the stop level and its high nibble holds the restart level. Each nibble counts in steps of four characters, so a threshold can be set anywhere from 0 to 60 characters.

When flow control is enabled, the line goes high (stop sending) once the queue reaches the stop threshold. It goes low again (keep sending) once the queue drains to the restart threshold. Between the two thresholds the line keeps its last value. This gap gives hysteresis.

A written pair is only accepted if the stop level is strictly above the restart level. Any other pair is replaced by the built-in defaults: stop nibble 15 (60 characters) and restart nibble 8 (32 characters). Thresholds are meant to be loaded before flow control is switched on. The queue storage and the receiver itself sit outside this block.

Top module: `rts_flow_ctrl`

## Requirements
- R1: After reset, `rts_n` is 0, the stop nibble is 15 and the restart nibble is 8.
- R2: With `cfg_we` high and `cfg_wdata[3:0]` strictly greater than `cfg_wdata[7:4]`, the stop nibble becomes `cfg_wdata[3:0]` and the restart nibble becomes `cfg_wdata[7:4]`. Each threshold equals its nibble times 4 characters. The new values first govern `rts_n` at the edge after the write edge.
- R3: With `cfg_we` high and `cfg_wdata[3:0]` less than or equal to `cfg_wdata[7:4]`, the stop nibble becomes 15 and the restart nibble becomes 8.
- R4: With `flow_en` high and `rx_level` at or above stop×4, `rts_n` is 1 after the next clock edge.
- R5: With `flow_en` high and `rx_level` at or below restart×4, `rts_n` is 0 after the next clock edge.
- R6: With `flow_en` high and `rx_level` strictly between restart×4 and stop×4, `rts_n` keeps its value across the edge.
- R7: With `flow_en` low, `rts_n` is 0 after the next clock edge, whatever the level.
- R8: Values on `cfg_wdata` while `cfg_we` is low leave both thresholds unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_level | input | 7 | Characters currently held in the receive queue (0 to 64) |
| flow_en | input | 1 | Enables automatic flow control |
| cfg_wdata | input | 8 | Threshold word: [7:4] restart nibble, [3:0] stop nibble |
| cfg_we | input | 1 | Write strobe for the threshold word |
| rts_n | output | 1 | Active-low request-to-send |

## Verification
The assertions check on every cycle that:
- `rts_n` follows the stop and restart comparisons against the thresholds in force;
- `rts_n` holds inside the hysteresis band;
- `rts_n` stays low while flow control is off;
- every strobed write stores either the written pair or the defaults.

Only the bench scenarios show the cases that depend on history:
- full level ramps up and down through the band;
- the one-cycle delay before a new pair takes effect;
- the narrowest legal pair;
- the effect of an unstrobed word on later behaviour.

// File: rtl/rts_flow_ctrl.sv
module rts_flow_ctrl #(
  parameter int DEPTH      = 64,
  parameter int NIB_W      = 4,
  parameter int STEP       = 4,
  parameter int DEF_STOP   = 15,
  parameter int DEF_GO     = 8,
  parameter int LVL_W      = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LVL_W-1:0]   rx_level,
  input  logic               flow_en,
  input  logic [2*NIB_W-1:0] cfg_wdata,
  input  logic               cfg_we,
  output logic               rts_n
);
  localparam int SH = $clog2(STEP);

  logic [NIB_W-1:0] stop_q, go_q;
  logic [NIB_W-1:0] wr_stop, wr_go;
  logic [LVL_W-1:0] stop_thr, go_thr;
  logic             rts_d;

  assign wr_stop  = cfg_wdata[NIB_W-1:0];
  assign wr_go    = cfg_wdata[2*NIB_W-1:NIB_W];
  assign stop_thr = LVL_W'(stop_q) << SH;
  assign go_thr   = LVL_W'(go_q) << SH;

  always_comb begin
    rts_d = rts_n;
    if (!flow_en)                rts_d = 1'b0;
    else if (rx_level >= stop_thr) rts_d = 1'b1;
    else if (rx_level <= go_thr)   rts_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= NIB_W'(DEF_STOP);
      go_q   <= NIB_W'(DEF_GO);
      rts_n  <= 1'b0;
    end else begin
      rts_n <= rts_d;
      if (cfg_we) begin
        if (wr_stop > wr_go) begin
          stop_q <= wr_stop;
          go_q   <= wr_go;
        end else begin
          stop_q <= NIB_W'(DEF_STOP);
          go_q   <= NIB_W'(DEF_GO);
        end
      end
    end
  end
endmodule

// File: rtl/rts_flow_ctrl_chk.sv
module rts_flow_ctrl_chk #(
  parameter int NIB_W    = 4,
  parameter int STEP     = 4,
  parameter int DEF_STOP = 15,
  parameter int DEF_GO   = 8,
  parameter int LVL_W    = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic [LVL_W-1:0]   rx_level,
  input logic               flow_en,
  input logic [2*NIB_W-1:0] cfg_wdata,
  input logic               cfg_we,
  input logic               rts_n,
  input logic [NIB_W-1:0]   stop_q,
  input logic [NIB_W-1:0]   go_q
);
  int stop_c, go_c;
  assign stop_c = int'(stop_q) * STEP;
  assign go_c   = int'(go_q) * STEP;

  // R4
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en && int'(rx_level) >= stop_c) |=> rts_n);
  // R5
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en && int'(rx_level) < stop_c && int'(rx_level) <= go_c) |=> !rts_n);
  // R6
  band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en && int'(rx_level) > go_c && int'(rx_level) < stop_c) |=> $stable(rts_n));
  // R7
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flow_en |=> !rts_n);
  // R2
  good_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[NIB_W-1:0] > cfg_wdata[2*NIB_W-1:NIB_W])
    |=> (stop_q == $past(cfg_wdata[NIB_W-1:0]) && go_q == $past(cfg_wdata[2*NIB_W-1:NIB_W])));
  // R3
  bad_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[NIB_W-1:0] <= cfg_wdata[2*NIB_W-1:NIB_W])
    |=> (stop_q == NIB_W'(DEF_STOP) && go_q == NIB_W'(DEF_GO)));
  // R8
  no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(stop_q) && $stable(go_q)));
endmodule

bind rts_flow_ctrl rts_flow_ctrl_chk #(
  .NIB_W(NIB_W), .STEP(STEP), .DEF_STOP(DEF_STOP), .DEF_GO(DEF_GO), .LVL_W(LVL_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .flow_en(flow_en),
  .cfg_wdata(cfg_wdata), .cfg_we(cfg_we), .rts_n(rts_n),
  .stop_q(stop_q), .go_q(go_q)
);

// File: tb/rts_flow_ctrl_tb_top.sv
`timescale 1ns/1ps
module rts_flow_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] rx_level = '0;
  logic       flow_en = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       cfg_we = 1'b0;
  logic       rts_n;

  int total = 0, bad = 0;
  int m_stop = 15, m_go = 8;
  logic m_rts = 1'b0;

  always #2 clk = ~clk;

  rts_flow_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .flow_en(flow_en),
    .cfg_wdata(cfg_wdata), .cfg_we(cfg_we), .rts_n(rts_n)
  );

  task automatic step(input int lvl, input bit en, input bit we, input logic [7:0] d, input string req);
    @(negedge clk);
    rx_level = 7'(lvl); flow_en = en; cfg_we = we; cfg_wdata = d;
    @(posedge clk);
    if (!en) m_rts = 1'b0;
    else if (lvl >= m_stop * 4) m_rts = 1'b1;
    else if (lvl <= m_go * 4) m_rts = 1'b0;
    if (we) begin
      if (int'(d[3:0]) > int'(d[7:4])) begin m_stop = d[3:0]; m_go = d[7:4]; end
      else begin m_stop = 15; m_go = 8; end
    end
    #1;
    total++;
    if (rts_n !== m_rts) begin
      bad++;
      $display("FAIL %s lvl=%0d en=%0b rts_n=%b exp=%b", req, lvl, en, rts_n, m_rts);
    end
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #5;
    total++;
    if (rts_n !== 1'b0) begin bad++; $display("FAIL R1 reset rts_n=%b exp=0", rts_n); end
    rst_n = 1'b1;
    // R1 default thresholds 60/32: ramp up and down
    for (int i = 0; i <= 64; i++) step(i, 1, 0, 8'h00, "R1 R4 R6 default ramp up");
    for (int i = 64; i >= 0; i--) step(i, 1, 0, 8'h00, "R1 R5 R6 default ramp down");
    // R2 restart 2, stop 10 (8..40 chars)
    step(0, 1, 1, 8'h2A, "R2 write valid");
    for (int i = 0; i <= 64; i += 3) step(i, 1, 0, 8'h00, "R2 R4 ramp up");
    for (int i = 64; i >= 0; i -= 2) step(i, 1, 0, 8'h00, "R2 R5 ramp down");
    // R2 new pair takes effect one edge after write
    step(20, 1, 1, 8'h14, "R2 write while level 20");
    step(20, 1, 0, 8'h00, "R2 R4 new stop 16");
    // R8 unstrobed invalid data ignored
    step(12, 1, 0, 8'hFF, "R8 no strobe");
    step(10, 1, 0, 8'hFF, "R8 no strobe band");
    step(4, 1, 0, 8'h00, "R8 R5 old restart 4");
    // R3 invalid pairs fall back to defaults
    step(0, 1, 1, 8'h55, "R3 equal pair");
    step(59, 1, 0, 8'h00, "R3 below 60");
    step(60, 1, 0, 8'h00, "R3 R4 at 60");
    step(33, 1, 0, 8'h00, "R3 R6 band");
    step(32, 1, 0, 8'h00, "R3 R5 at 32");
    step(0, 1, 1, 8'h93, "R3 reversed pair");
    step(40, 1, 0, 8'h00, "R3 R6 band");
    step(12, 1, 0, 8'h00, "R3 old 3 not used");
    // narrowest legal pair: restart 0, stop 1
    step(0, 1, 1, 8'h01, "R2 narrow write");
    for (int i = 0; i <= 5; i++) step(i, 1, 0, 8'h00, "R4 R6 narrow up");
    for (int i = 5; i >= 0; i--) step(i, 1, 0, 8'h00, "R5 R6 narrow down");
    // R7 disabled keeps line low
    step(64, 1, 0, 8'h00, "R4 full");
    step(64, 0, 0, 8'h00, "R7 disabled at full");
    step(64, 0, 0, 8'h00, "R7 disabled hold");
    step(2, 1, 0, 8'h00, "R6 band after enable");
    step(4, 1, 0, 8'h00, "R4 after enable");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule